// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns one parallel byte into an asynchronous serial frame. Each clock period is one bit time, so the block must be clocked at the line bit rate. A frame is a low start bit, then the data bits with the least significant bit first, then an odd parity bit, then a high stop bit. With the default data width a frame is eleven bit times long. Between frames the line rests at the high mark level.

The block has no explicit state machine. A shift register is loaded with parity, data and start bit together. It shifts right on every clock and fills from the top with ones, and those ones supply the stop bit and the idle mark. A modulo-frame down counter tracks the frame. Its zero terminal count is the ready flag and also gates new writes. A write strobe is accepted only while ready is high. A strobe that arrives during a frame is discarded.

Top module: `serial_frame_tx`

## Requirements
- R1: While `rst_i` is high at a rising edge, the next cycle shows `tx_o` = 1 and `ready_o` = 1, even if a frame was in progress.
- R2: While `ready_o` is high and no write is accepted, `tx_o` stays at 1 (mark).
- R3: In the cycle after a write is accepted (`wr_i` = 1 while `ready_o` = 1), `tx_o` is 0 (the start bit).
- R4: In the 8 cycles after the start bit, `tx_o` carries `data_i` bits 0 through 7 in that order, as captured at the accepting edge.
- R5: In the cycle after the last data bit, `tx_o` carries the odd parity bit, so the data bits plus this bit hold an odd number of ones.
- R6: In the cycle after the parity bit, `tx_o` is 1 (the stop bit) and `ready_o` is already high.
- R7: After an accepted write, `ready_o` is low for exactly 10 consecutive cycles and then returns high.
- R8: A write strobe while `ready_o` is low is ignored: the frame in progress, its bit values and its `ready_o` timing are unchanged.
- R9: A write made in the first cycle in which `ready_o` is back high is accepted, so its start bit directly follows the previous stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit-rate clock; each period is one bit time |
| rst_i | input | 1 | Synchronous reset, active high |
| data_i | input | 8 | Byte to transmit, sampled when a write is accepted |
| wr_i | input | 1 | Single-cycle write strobe |
| tx_o | output | 1 | Serial line output, idles high |
| ready_o | output | 1 | High when a new byte can be accepted |

## Verification
The bench builds the block with its default data width of eight. That gives an eleven-bit frame and a counter whose modulus, eleven, is not a power of two, so the wrap from zero to ten and the return to zero are both exercised. Random bytes reach both parity values and many bit patterns. Random idle gaps of zero cycles produce back-to-back frames. Strobes injected during busy cycles cover the discard path, and a reset in mid-frame shows that an abort restores the mark level.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    localparam logic LINE_MARK  = 1'b1;
    localparam logic LINE_START = 1'b0;

    // start + data + parity + stop
    function automatic int frame_bits(input int data_w);
        return data_w + 3;
    endfunction

    // register holds everything except the stop bit, which is shifted in
    function automatic int shreg_bits(input int data_w);
        return data_w + 2;
    endfunction

endpackage

// File: rtl/tx_parity_gen.sv
module tx_parity_gen #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data_i,
    output logic             par_o
);
    // XOR chain: chain[k] is the even parity of data_i[k-1:0]
    logic [WIDTH:0] chain;

    assign chain[0] = 1'b0;

    for (genvar k = 0; k < WIDTH; k++) begin : g_xor
        assign chain[k+1] = chain[k] ^ data_i[k];
    end

    // odd parity: total ones including this bit is odd
    assign par_o = ~chain[WIDTH];

endmodule

// File: rtl/tx_shift_reg.sv
module tx_shift_reg
    import serial_tx_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] word_i,
    output logic             ser_o
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } shreg_t;

    shreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.bits = word_i;
        end else begin
            st_d.bits = {LINE_MARK, st_q.bits[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.bits <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_o = st_q.bits[0];

endmodule

// File: rtl/tx_frame_ctr.sv
module tx_frame_ctr #(
    parameter int MODULUS = 11,
    localparam int CW     = $clog2(MODULUS)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic tc_o
);
    localparam logic [CW-1:0] TOP = CW'(MODULUS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;
    logic tc;
    logic en;

    assign tc = (st_q.cnt == '0);
    assign en = start_i | ~tc;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (tc) begin
                st_d.cnt = TOP;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tc_o = tc;

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              wr_i,
    output logic              tx_o,
    output logic              ready_o
);
    localparam int FRAME_LEN = frame_bits(DATA_W);
    localparam int SHREG_W   = shreg_bits(DATA_W);

    logic               idle;
    logic               accept;
    logic               par;
    logic [SHREG_W-1:0] word;

    // writes only while idle, so a running frame is never disturbed
    assign accept = wr_i & idle;
    assign word   = {par, data_i, LINE_START};

    tx_parity_gen #(.WIDTH(DATA_W)) u_par (
        .data_i (data_i),
        .par_o  (par)
    );

    tx_shift_reg #(.WIDTH(SHREG_W)) u_shreg (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (accept),
        .word_i (word),
        .ser_o  (tx_o)
    );

    tx_frame_ctr #(.MODULUS(FRAME_LEN)) u_ctr (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (accept),
        .tc_o    (idle)
    );

    assign ready_o = idle;

endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [DATA_W-1:0] data_i,
    input logic              wr_i,
    input logic              tx_o,
    input logic              ready_o
);
    localparam int FRAME_LEN = frame_bits(DATA_W);
    localparam int PW        = $clog2(FRAME_LEN + 1);

    // independent frame-position model: 0 = idle/stop, 1 = start,
    // 2..DATA_W+1 = data, DATA_W+2 = parity
    logic [PW-1:0]     pos_q;
    logic [DATA_W-1:0] cap_q;
    logic              exp_data_bit;
    int                idx;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pos_q <= '0;
            cap_q <= '0;
        end else if (pos_q == '0) begin
            if (wr_i) begin
                pos_q <= PW'(1);
                cap_q <= data_i;
            end
        end else if (pos_q == PW'(FRAME_LEN - 1)) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    always_comb begin
        idx = int'(pos_q) - 2;
        exp_data_bit = 1'b0;
        if (idx >= 0 && idx < DATA_W) begin
            exp_data_bit = cap_q[idx];
        end
    end

    assert_reset_R1: assert property (@(posedge clk_i)
        rst_i |=> (tx_o && ready_o));

    assert_mark_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (pos_q == '0) |-> tx_o);

    assert_start_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (ready_o && wr_i) |=> (!tx_o && !ready_o));

    assert_data_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (pos_q >= PW'(2) && pos_q <= PW'(DATA_W + 1)) |-> (tx_o == exp_data_bit));

    assert_parity_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (pos_q == PW'(DATA_W + 2)) |-> (tx_o == ~(^cap_q)));

    // R8: the model ignores strobes while busy, so ready must track it
    assert_busy_len_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o == (pos_q == '0));

    assert_stop_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ready_o) |-> tx_o);

endmodule

bind serial_frame_tx serial_frame_tx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .data_i  (data_i),
    .wr_i    (wr_i),
    .tx_o    (tx_o),
    .ready_o (ready_o)
);

// File: tb/serial_frame_tx_tb_top.sv
module serial_frame_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] data = 8'h00;
    logic       wr = 1'b0;
    logic       tx;
    logic       rdy;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    serial_frame_tx #(.DATA_W(8)) dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .data_i  (data),
        .wr_i    (wr),
        .tx_o    (tx),
        .ready_o (rdy)
    );

    function automatic logic odd_par(input logic [7:0] d);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(d[i]);
        return (ones % 2 == 0) ? 1'b1 : 1'b0;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // apply inputs, take one rising edge, outputs then reflect that edge
    task automatic cyc(input logic w, input logic [7:0] d);
        wr   = w;
        data = d;
        @(posedge clk);
        #2;
    endtask

    // sends one frame; noise = inject ignored strobes while busy (R8)
    task automatic send(input logic [7:0] d, input bit noise);
        cyc(1'b1, d);
        check("R3 start bit", tx, 1'b0);
        check("R7 ready low", rdy, 1'b0);
        for (int i = 0; i < 8; i++) begin
            cyc(noise ? 1'b1 : 1'b0, noise ? 8'($urandom) : 8'h00);
            check(noise ? "R8 data under strobe" : "R4 data bit", tx, d[i]);
            check("R7 ready low", rdy, 1'b0);
        end
        cyc(noise ? 1'b1 : 1'b0, 8'($urandom));
        check("R5 parity", tx, odd_par(d));
        check("R7 ready low", rdy, 1'b0);
        cyc(1'b0, 8'h00);
        check("R6 stop bit", tx, 1'b1);
        check("R6 ready at stop", rdy, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(posedge clk); #2;
        cyc(1'b1, 8'h5A);
        check("R1 reset tx", tx, 1'b1);
        check("R1 reset ready", rdy, 1'b1);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 8'($urandom));
            check("R2 idle mark", tx, 1'b1);
            check("R2 idle ready", rdy, 1'b1);
        end
        // directed corner bytes
        send(8'h00, 1'b0);
        send(8'hFF, 1'b0);
        send(8'h01, 1'b1);
        // R9 back-to-back: the write follows the stop bit directly
        send(8'hA5, 1'b0);
        send(8'h80, 1'b0);
        // R1 reset in mid-frame aborts it
        cyc(1'b1, 8'h00);
        cyc(1'b0, 8'h00);
        cyc(1'b0, 8'h00);
        rst = 1'b1;
        cyc(1'b0, 8'h00);
        check("R1 abort tx", tx, 1'b1);
        check("R1 abort ready", rdy, 1'b1);
        rst = 1'b0;
        cyc(1'b0, 8'h00);
        check("R2 mark after abort", tx, 1'b1);
        // random frames with random gaps (gap 0 exercises R9)
        for (int f = 0; f < 40; f++) begin
            int gap = int'($urandom % 4);
            for (int g = 0; g < gap; g++) begin
                cyc(1'b0, 8'($urandom));
                check("R2 idle mark", tx, 1'b1);
            end
            send(8'($urandom), bit'($urandom % 2));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule